// File: doc/BRIEF.md
# Multi-channel DMA priority arbiter

This block decides, one cycle at a time, which of eight DMA channels may use a shared memory engine. Channels 0 to 5 move frames from memory into the switch (injection). Channels 6 and 7 move frames out of the switch (extraction). The channels feed two CPU ports. Each channel drives a request, an enable and an end-of-frame flag for the beat it would move if chosen. Each injection channel also has a routing bit that picks its CPU port.

Arbitration works in two levels. Inside one port a strict order applies. The port's extraction channel wins whenever it can go. Otherwise the port's injection owner goes. An owner keeps its port until it moves a beat flagged as end of frame. When a port has no owner, the highest-numbered injection channel routed to it takes ownership. Between the two ports, a two-state turn machine gives the engine to the ports in alternation while both have work. A port that is alone gets every cycle.

Each lane has a state machine with two states. `OWN_IDLE` means no owner. `OWN_HELD` means a channel owns the port.
- CLAIM (`OWN_IDLE`→`OWN_HELD`): an injection beat without end of frame is granted.
- RELEASE_EOF (`OWN_HELD`→`OWN_IDLE`): the owner is granted a beat flagged end of frame.
- RELEASE_DIS (`OWN_HELD`→`OWN_IDLE`): the owner's enable drops.

A single-beat frame granted in `OWN_IDLE` stays in `OWN_IDLE`.

The turn machine has two states, `TURN_P0` and `TURN_P1`.
- PASS: after a grant, the turn moves to the other port if that port has work.
- KEEP: otherwise the turn stays with the port just served.

The grant, its index and its valid flag are registered. They appear one cycle after the inputs that produced them.

Top module: `dma_prio_arb`

## Requirements
- R1: During and right after reset, `gnt` is 0, `gnt_vld` is 0 and `gnt_idx` is 0.
- R2: Output timing and encoding:
  - the grant appears on the clock edge after the inputs that cause it;
  - `gnt` is one-hot or zero, with bit i meaning channel i;
  - `gnt_vld` is high exactly when `gnt` is non-zero;
  - `gnt_idx` is the binary index of the set bit, and 0 when nothing is granted.
- R3: A channel whose `ch_en` bit is 0 is never granted, whatever its `ch_req` bit.
- R4: Channel 6 belongs to port 0 and channel 7 to port 1. When a port's extraction channel requests and is enabled, that port offers it ahead of any injection channel. When both extraction channels request, an extraction channel is granted.
- R5: Routing bit `inj_port_sel[i]` = 0 sends injection channel i to port 0, and 1 sends it to port 1. With no owner on a port, the highest-numbered live injection channel routed there is granted and becomes owner, unless its first beat carries end of frame.
- R6: An owner keeps its port until one of its granted beats carries `ch_eof`. While it holds the port, other injection channels of that port wait, even higher-numbered ones. After the end-of-frame beat, the port is re-arbitrated.
- R7: Changing the routing bit of an owner in mid-frame does not move the owner off its port before its frame ends.
- R8: If an owner's enable drops, ownership is released at the next edge, and the port is re-arbitrated from the next cycle.
- R9: While both ports have work, grants alternate between the ports. A port with work alone is granted every cycle.
- R10: A channel that owns one port is never claimed by the other port, even if its routing bit now points there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch_req | input | 8 | Per-channel request |
| ch_en | input | 8 | Per-channel enable |
| ch_eof | input | 8 | Per-channel end-of-frame flag for the offered beat |
| inj_port_sel | input | 6 | Port routing bit of each injection channel |
| gnt | output | 8 | Registered one-hot grant |
| gnt_vld | output | 1 | A channel is granted this cycle |
| gnt_idx | output | 3 | Index of the granted channel |

## Verification
The checker tests these properties on every cycle:
- the one-hot grant and its agreement with the index;
- that no channel is granted without being enabled and requesting the cycle before;
- that an extraction channel wins when both extraction channels request;
- that an owner's index stays fixed while held, and that a disabled owner is released;
- that no channel owns both ports;
- the alternation of turns whenever the other port was busy.

Only the bench scenarios can show the choices that need history:
- which channel claims an idle port;
- that a higher-numbered channel waits for the owner's end of frame;
- that a mid-frame routing change has no effect.

A cycle-by-cycle reference model covers these, in directed sequences and in a long random run.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    localparam int N_PORT = 2;

    typedef enum logic [0:0] {
        OWN_IDLE = 1'b0,
        OWN_HELD = 1'b1
    } own_state_e;

    typedef enum logic [0:0] {
        TURN_P0 = 1'b0,
        TURN_P1 = 1'b1
    } turn_state_e;

endpackage

// File: rtl/dma_arb_lane.sv
// One CPU port: picks its candidate channel and tracks injection ownership.
module dma_arb_lane
    import dma_arb_pkg::*;
#(
    parameter  int N_INJ   = 6,
    parameter  int PORT_ID = 0,
    localparam int N_CH    = N_INJ + N_PORT,
    localparam int IDX_W   = $clog2(N_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_INJ-1:0] inj_live,
    input  logic [N_INJ-1:0] inj_en,
    input  logic [N_INJ-1:0] inj_here,
    input  logic             xtr_live,
    input  logic [N_CH-1:0]  eof_vec,
    input  logic             peer_own_vld,
    input  logic [IDX_W-1:0] peer_own_idx,
    input  logic             take,
    output logic             has_work,
    output logic [IDX_W-1:0] cand_idx,
    output logic             own_vld,
    output logic [IDX_W-1:0] own_idx
);

    localparam logic [IDX_W-1:0] XTR_IDX = IDX_W'(N_INJ + PORT_ID);

    own_state_e       state_q, state_d;
    logic [IDX_W-1:0] own_q, own_d;
    logic             claim_found;
    logic [IDX_W-1:0] claim_idx;
    logic             owner_live;
    logic             owner_en;
    logic             inj_found;
    logic [IDX_W-1:0] inj_idx;
    logic             cand_eof;
    logic             inj_take;

    // Highest-numbered live channel routed here and not owned by the peer.
    always_comb begin
        claim_found = 1'b0;
        claim_idx   = '0;
        for (int i = 0; i < N_INJ; i++) begin
            if (inj_live[i] && inj_here[i] &&
                !(peer_own_vld && (peer_own_idx == IDX_W'(i)))) begin
                claim_found = 1'b1;
                claim_idx   = IDX_W'(i);
            end
        end
    end

    always_comb begin
        owner_live = 1'b0;
        owner_en   = 1'b0;
        for (int i = 0; i < N_INJ; i++) begin
            if (own_q == IDX_W'(i)) begin
                owner_live = inj_live[i];
                owner_en   = inj_en[i];
            end
        end
    end

    // Output process: candidate and ownership view.
    always_comb begin
        inj_found = 1'b0;
        inj_idx   = '0;
        unique case (state_q)
            OWN_IDLE: begin
                inj_found = claim_found;
                inj_idx   = claim_idx;
            end
            OWN_HELD: begin
                inj_found = owner_live;
                inj_idx   = own_q;
            end
            default: begin
                inj_found = 1'b0;
                inj_idx   = '0;
            end
        endcase
        has_work = xtr_live || inj_found;
        cand_idx = xtr_live ? XTR_IDX : inj_idx;
        own_vld  = (state_q == OWN_HELD);
        own_idx  = own_q;
    end

    always_comb begin
        cand_eof = 1'b0;
        for (int i = 0; i < N_CH; i++) begin
            if (cand_idx == IDX_W'(i)) cand_eof = eof_vec[i];
        end
    end

    assign inj_take = take && !xtr_live;

    // Next-state: CLAIM, RELEASE_EOF, RELEASE_DIS.
    always_comb begin
        state_d = state_q;
        own_d   = own_q;
        unique case (state_q)
            OWN_IDLE: begin
                if (inj_take && claim_found && !cand_eof) begin
                    state_d = OWN_HELD;
                    own_d   = claim_idx;
                end
            end
            OWN_HELD: begin
                if (inj_take && owner_live && cand_eof) begin
                    state_d = OWN_IDLE;
                end else if (!owner_en) begin
                    state_d = OWN_IDLE;
                end
            end
            default: state_d = OWN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OWN_IDLE;
            own_q   <= '0;
        end else begin
            state_q <= state_d;
            own_q   <= own_d;
        end
    end

endmodule

// File: rtl/dma_arb_turn.sv
// Two-port turn keeper: alternates while both ports have work.
module dma_arb_turn
    import dma_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] work,
    output logic       pick,
    output logic       pick_vld
);

    turn_state_e state_q, state_d;

    always_comb begin
        pick_vld = |work;
        unique case (state_q)
            TURN_P0: pick = (work == 2'b11) ? 1'b0 : work[1];
            TURN_P1: pick = (work == 2'b11) ? 1'b1 : work[1];
            default: pick = work[1];
        endcase
    end

    // PASS to the other port if it waits, else KEEP the served one.
    always_comb begin
        state_d = state_q;
        if (pick_vld) begin
            if (work[~pick]) state_d = pick ? TURN_P0 : TURN_P1;
            else             state_d = pick ? TURN_P1 : TURN_P0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TURN_P0;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
    import dma_arb_pkg::*;
#(
    parameter  int N_INJ = 6,
    localparam int N_CH  = N_INJ + N_PORT,
    localparam int IDX_W = $clog2(N_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CH-1:0]  ch_req,
    input  logic [N_CH-1:0]  ch_en,
    input  logic [N_CH-1:0]  ch_eof,
    input  logic [N_INJ-1:0] inj_port_sel,
    output logic [N_CH-1:0]  gnt,
    output logic             gnt_vld,
    output logic [IDX_W-1:0] gnt_idx
);

    logic [N_CH-1:0]             live;
    logic [1:0]                  lane_work;
    logic [1:0][IDX_W-1:0]       cand_idx;
    logic [1:0]                  own_vld;
    logic [1:0][IDX_W-1:0]       own_idx;
    logic                        port_pick;
    logic                        port_pick_vld;
    logic [IDX_W-1:0]            sel_idx;
    logic [N_CH-1:0]             gnt_d;
    logic [IDX_W-1:0]            idx_d;
    logic [N_CH-1:0]             gnt_q;
    logic [IDX_W-1:0]            idx_q;
    logic                        vld_q;

    assign live = ch_req & ch_en;

    for (genvar p = 0; p < N_PORT; p++) begin : g_lane
        logic [N_INJ-1:0] here;
        logic             take;
        assign here = (p == 0) ? ~inj_port_sel : inj_port_sel;
        assign take = port_pick_vld && (port_pick == 1'(p));

        dma_arb_lane #(
            .N_INJ   (N_INJ),
            .PORT_ID (p)
        ) u_lane (
            .clk          (clk),
            .rst_n        (rst_n),
            .inj_live     (live[N_INJ-1:0]),
            .inj_en       (ch_en[N_INJ-1:0]),
            .inj_here     (here),
            .xtr_live     (live[N_INJ+p]),
            .eof_vec      (ch_eof),
            .peer_own_vld (own_vld[1-p]),
            .peer_own_idx (own_idx[1-p]),
            .take         (take),
            .has_work     (lane_work[p]),
            .cand_idx     (cand_idx[p]),
            .own_vld      (own_vld[p]),
            .own_idx      (own_idx[p])
        );
    end

    dma_arb_turn u_turn (
        .clk      (clk),
        .rst_n    (rst_n),
        .work     (lane_work),
        .pick     (port_pick),
        .pick_vld (port_pick_vld)
    );

    assign sel_idx = cand_idx[port_pick];

    always_comb begin
        gnt_d = '0;
        idx_d = '0;
        if (port_pick_vld) begin
            idx_d = sel_idx;
            for (int i = 0; i < N_CH; i++) begin
                if (sel_idx == IDX_W'(i)) gnt_d[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gnt_q <= '0;
            idx_q <= '0;
            vld_q <= 1'b0;
        end else begin
            gnt_q <= gnt_d;
            idx_q <= idx_d;
            vld_q <= port_pick_vld;
        end
    end

    assign gnt     = gnt_q;
    assign gnt_idx = idx_q;
    assign gnt_vld = vld_q;

endmodule

// File: rtl/dma_prio_arb_chk.sv
module dma_prio_arb_chk #(
    parameter  int N_INJ = 6,
    localparam int N_CH  = N_INJ + 2,
    localparam int IDX_W = $clog2(N_CH)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [N_CH-1:0]       ch_req,
    input logic [N_CH-1:0]       ch_en,
    input logic [N_CH-1:0]       gnt,
    input logic                  gnt_vld,
    input logic [IDX_W-1:0]      gnt_idx,
    input logic [1:0]            lane_work,
    input logic                  port_pick,
    input logic                  port_pick_vld,
    input logic [1:0]            own_vld,
    input logic [1:0][IDX_W-1:0] own_idx
);

    logic armed_q;
    logic prev_ok_q;
    logic prev_pick_q;
    logic xtr_both;

    assign xtr_both = &(ch_req[N_CH-1:N_INJ] & ch_en[N_CH-1:N_INJ]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q     <= 1'b0;
            prev_ok_q   <= 1'b0;
            prev_pick_q <= 1'b0;
        end else begin
            armed_q     <= 1'b1;
            prev_ok_q   <= port_pick_vld && lane_work[~port_pick];
            prev_pick_q <= port_pick;
        end
    end

    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt) && (gnt_vld == (gnt != '0)));

    p_idx_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld |-> gnt[gnt_idx]);

    p_enabled_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> ((gnt & ~$past(ch_en & ch_req)) == '0));

    p_xtr_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(xtr_both)) |-> (gnt_vld && (gnt_idx >= IDX_W'(N_INJ))));

    p_alternate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_ok_q && lane_work[~prev_pick_q]) |-> (port_pick_vld && (port_pick != prev_pick_q)));

    p_no_shared_owner_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !((own_vld == 2'b11) && (own_idx[0] == own_idx[1])));

    for (genvar p = 0; p < 2; p++) begin : g_own
        p_owner_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (own_vld[p] && $past(own_vld[p])) |-> (own_idx[p] == $past(own_idx[p])));

        p_disable_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (own_vld[p] && !ch_en[own_idx[p]]) |=> !own_vld[p]);
    end

endmodule

bind dma_prio_arb dma_prio_arb_chk #(.N_INJ(N_INJ)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ch_req        (ch_req),
    .ch_en         (ch_en),
    .gnt           (gnt),
    .gnt_vld       (gnt_vld),
    .gnt_idx       (gnt_idx),
    .lane_work     (lane_work),
    .port_pick     (port_pick),
    .port_pick_vld (port_pick_vld),
    .own_vld       (own_vld),
    .own_idx       (own_idx)
);

// File: tb/tb_dma_prio_arb.sv
`timescale 1ns/1ps
module tb_dma_prio_arb;

    localparam int NI = 6;
    localparam int NC = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] ch_req = '0;
    logic [NC-1:0] ch_en = '0;
    logic [NC-1:0] ch_eof = '0;
    logic [NI-1:0] inj_port_sel = '0;
    logic [NC-1:0] gnt;
    logic          gnt_vld;
    logic [2:0]    gnt_idx;

    int    n_tests = 0;
    int    n_fail = 0;
    string cur_tag = "R1";

    always #2 clk = ~clk;

    dma_prio_arb dut (
        .clk(clk), .rst_n(rst_n), .ch_req(ch_req), .ch_en(ch_en),
        .ch_eof(ch_eof), .inj_port_sel(inj_port_sel),
        .gnt(gnt), .gnt_vld(gnt_vld), .gnt_idx(gnt_idx)
    );

    // Behavioural reference model.
    int            m_own[2];
    int            m_ptr;
    logic [NC-1:0] m_gnt;
    int            m_idx;
    bit            m_vld;

    always @(posedge clk) begin
        int cand[2];
        int pk;
        int g;
        logic [NC-1:0] lv;
        if (!rst_n) begin
            m_own[0] = -1; m_own[1] = -1; m_ptr = 0;
            m_gnt = '0; m_idx = 0; m_vld = 0;
        end else begin
            lv = ch_req & ch_en;
            for (int p = 0; p < 2; p++) begin
                cand[p] = -1;
                if (lv[NI+p]) cand[p] = NI + p;
                else if (m_own[p] >= 0) begin
                    if (lv[m_own[p]]) cand[p] = m_own[p];
                end else begin
                    for (int i = NI - 1; i >= 0; i--)
                        if (cand[p] < 0 && lv[i] && (int'(inj_port_sel[i]) == p) && m_own[1-p] != i)
                            cand[p] = i;
                end
            end
            if (cand[0] >= 0 && cand[1] >= 0) pk = m_ptr;
            else if (cand[1] >= 0)            pk = 1;
            else if (cand[0] >= 0)            pk = 0;
            else                              pk = -1;
            if (pk >= 0) begin
                g = cand[pk];
                m_gnt = NC'(1) << g; m_idx = g; m_vld = 1;
                if (g < NI) begin
                    if (m_own[pk] < 0) begin
                        if (!ch_eof[g]) m_own[pk] = g;
                    end else if (ch_eof[g]) m_own[pk] = -1;
                end
                m_ptr = (cand[1-pk] >= 0) ? 1 - pk : pk;
            end else begin
                m_gnt = '0; m_idx = 0; m_vld = 0;
            end
            for (int p = 0; p < 2; p++)
                if (m_own[p] >= 0 && !ch_en[m_own[p]]) m_own[p] = -1;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            n_tests++;
            if (gnt !== m_gnt || gnt_vld !== m_vld || int'(gnt_idx) != m_idx) begin
                n_fail++;
                $display("FAIL %s model: gnt=%b vld=%0b idx=%0d expected gnt=%b vld=%0b idx=%0d",
                         cur_tag, gnt, gnt_vld, gnt_idx, m_gnt, m_vld, m_idx);
            end
        end
    end

    task automatic drive(logic [NC-1:0] r, logic [NC-1:0] e, logic [NC-1:0] f, logic [NI-1:0] s);
        ch_req = r; ch_en = e; ch_eof = f; inj_port_sel = s;
    endtask

    task automatic expect_grant(string tag, bit vld, int idx);
        logic [NC-1:0] eg;
        @(negedge clk);
        eg = vld ? (NC'(1) << idx) : '0;
        n_tests++;
        if (gnt_vld !== vld || gnt !== eg || int'(gnt_idx) != (vld ? idx : 0)) begin
            n_fail++;
            $display("FAIL %s: gnt=%b vld=%0b idx=%0d expected gnt=%b vld=%0b idx=%0d",
                     tag, gnt, gnt_vld, gnt_idx, eg, vld, vld ? idx : 0);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        drive('0, 8'hFF, '0, '0);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: outputs idle during reset
        n_tests++;
        if (gnt !== '0 || gnt_vld !== 1'b0 || gnt_idx !== '0) begin
            n_fail++;
            $display("FAIL R1: gnt=%b vld=%0b idx=%0d expected 0 0 0", gnt, gnt_vld, gnt_idx);
        end
        rst_n = 1'b1;
        expect_grant("R1", 0, 0);

        cur_tag = "R3";
        drive(8'hFF, 8'h00, '0, '0);       expect_grant("R3", 0, 0);
        drive(8'h80, 8'h7F, '0, '0);       expect_grant("R3", 0, 0);

        cur_tag = "R4";
        drive(8'h60, 8'hFF, '0, '0);       expect_grant("R4", 1, 6);
        drive(8'h80, 8'hFF, '0, '0);       expect_grant("R4", 1, 7);

        cur_tag = "R5";
        drive(8'h0A, 8'hFF, '0, '0);       expect_grant("R5", 1, 3);

        cur_tag = "R6";
        drive(8'h1A, 8'hFF, '0, '0);       expect_grant("R6", 1, 3);
        drive(8'h1A, 8'hFF, 8'h08, '0);    expect_grant("R6", 1, 3);
        drive(8'h1A, 8'hFF, '0, '0);       expect_grant("R6", 1, 4);

        cur_tag = "R7";
        drive(8'h30, 8'hFF, '0, 6'h30);    expect_grant("R7", 1, 4);
        expect_grant("R7", 1, 5);
        expect_grant("R7", 1, 4);

        do_reset();
        cur_tag = "R8";
        drive(8'h06, 8'hFF, '0, '0);       expect_grant("R8", 1, 2);
        drive(8'h06, 8'hFB, '0, '0);       expect_grant("R8", 0, 0);
        expect_grant("R8", 1, 1);

        do_reset();
        cur_tag = "R9";
        drive(8'hC0, 8'hFF, '0, '0);       expect_grant("R9", 1, 6);
        expect_grant("R9", 1, 7);
        expect_grant("R9", 1, 6);
        drive(8'h40, 8'hFF, '0, '0);       expect_grant("R9", 1, 6);
        expect_grant("R9", 1, 6);

        do_reset();
        cur_tag = "R10";
        drive(8'h08, 8'hFF, '0, '0);       expect_grant("R10", 1, 3);
        drive(8'h0A, 8'hFF, '0, 6'h0A);    expect_grant("R10", 1, 3);
        expect_grant("R10", 1, 1);

        // R2: long random run against the model
        do_reset();
        cur_tag = "R2";
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            ch_req = NC'($urandom);
            ch_en  = NC'($urandom) | NC'($urandom) | NC'($urandom);
            ch_eof = NC'($urandom) & NC'($urandom);
            if (($urandom % 16) == 0) inj_port_sel = NI'($urandom);
        end
        @(negedge clk);
        drive('0, 8'hFF, '0, '0);
        repeat (2) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule